// File: doc/BRIEF.md
# Radio Idle Power-Mode Controller

This controller sets the power state of a low-power radio's analog section. It holds a mode-control register and a crystal-control register behind a small parallel register port. From them it picks one of five idle states, or shutdown, and drives one enable line for each of these sub-blocks: the low-power regulator, the wake-up timer, the battery detector, the temperature sensor, the crystal oscillator, the oscillator buffer and the PLL.

A shutdown pin overrides everything. When the pin falls, a power-on reset returns the registers to their defaults. The block also follows an active-low interrupt line. In the three deepest idle states, the minimum-current indication stays low until the host has pulsed an interrupt-status-read strobe.

All outputs are registered. A register write reaches the enable lines on the second rising edge after the write is sampled. Read data appears on the first edge after the read strobe.

Top module: `radio_idle_pmc`

## Requirements
- R1: While `rst` is high, all enables are 0, `mode_code` is 0 and `min_current` is 0. On the first edge after `rst` falls, the block reports READY (code 4) with the regulator, crystal and buffer on. The mode register reads 0x01 and the crystal-control register reads 0x00.
- R2: While `shdn` is high, every enable, `mode_code` and `min_current` is 0. Register writes are ignored and reads return 0x00.
- R3: On the edge where `shdn` is first seen low, the outputs stay off for one cycle, and both registers take their defaults whatever they held before. On the next edge the block reports READY.
- R4: The mode register sits at address 0. Writing 0x00 to it selects STANDBY (code 1), in which only the regulator is enabled.
- R5: Mode-register bit 6 selects SLEEP (code 2), which enables the regulator and the wake-up timer.
- R6: Bit 5 (battery detect) or bit 4 (temperature sense) selects SENSOR (code 3). SENSOR forces the wake-up timer on. The battery-detector and temperature-sensor enables follow bits 5 and 4 in every non-shutdown state.
- R7: Bit 0 selects READY (code 4). The crystal is on there. The buffer is on unless bit 1 of the crystal-control register (address 1, a full 8-bit read/write register) is 1.
- R8: Bit 1 selects TUNE (code 5), which enables the PLL and the crystal even when bit 0 is clear.
- R9: The decode order, highest first, is TUNE, READY, SENSOR, SLEEP, STANDBY.
- R10: While the decoded state is READY and crystal-control bit 1 is 1, a mode-register write that would decode to any other state is dropped and the register keeps its value.
- R11: Writing the mode register with bit 7 set restores both registers to their defaults and ignores the other written bits. The mode register stores only bits 6, 5, 4, 1 and 0. Bits 7, 3 and 2 read 0.
- R12: `min_current` is 1 only in STANDBY, SLEEP or SENSOR while no interrupt read is pending. A read becomes pending on reset, on power-on reset and on each falling edge of `irq_n`. It is cleared by `irq_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| shdn | input | 1 | Shutdown pin, high = shutdown |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid one edge after `rd_en` |
| irq_n | input | 1 | Interrupt line, active low |
| irq_rd | input | 1 | Interrupt status has been read |
| en_ldo | output | 1 | Low-power regulator enable |
| en_wut | output | 1 | Wake-up timer enable |
| en_lbd | output | 1 | Battery detector enable |
| en_tsen | output | 1 | Temperature sensor enable |
| en_xtal | output | 1 | Crystal oscillator enable |
| en_xbuf | output | 1 | Oscillator buffer enable |
| en_pll | output | 1 | PLL enable |
| mode_code | output | 3 | 0 off, 1 STANDBY, 2 SLEEP, 3 SENSOR, 4 READY, 5 TUNE |
| min_current | output | 1 | Low-power state reached with no pending interrupt read |

## Verification
A wrong decode or a wrong register bit shows on `mode_code` and on the enable lines two edges after the write that caused it. Register readback exposes the stored bits one edge after a read strobe. A dropped write under buffer override therefore shows as an unchanged readback and an unchanged mode code. A pending flag that is stuck, or that sets on the wrong edge, shows as `min_current` staying low, or rising too early, two edges after the interrupt line falls or the read strobe is pulsed.

// File: rtl/pmc_pkg.sv
`timescale 1ns/1ps
package pmc_pkg;
  localparam int REG_W    = 8;
  localparam int B_SWRST  = 7;
  localparam int B_WUT    = 6;
  localparam int B_LBD    = 5;
  localparam int B_TS     = 4;
  localparam int B_PLL    = 1;
  localparam int B_XON    = 0;
  localparam int B_BUFOVR = 1;
  localparam int EN_W     = 7;

  typedef enum logic [2:0] {
    PM_OFF   = 3'd0,
    PM_STBY  = 3'd1,
    PM_SLEEP = 3'd2,
    PM_SENSE = 3'd3,
    PM_READY = 3'd4,
    PM_TUNE  = 3'd5
  } pm_mode_e;

  typedef struct packed {
    logic wut;
    logic lbd;
    logic ts;
    logic pll;
    logic xon;
  } ctl_t;

  localparam ctl_t CTL_DEF = '{wut: 1'b0, lbd: 1'b0, ts: 1'b0, pll: 1'b0, xon: 1'b1};
  localparam logic [REG_W-1:0] XCTL_DEF = '0;

  function automatic ctl_t ctl_of(input logic [REG_W-1:0] d);
    ctl_t c;
    c.wut = d[B_WUT];
    c.lbd = d[B_LBD];
    c.ts  = d[B_TS];
    c.pll = d[B_PLL];
    c.xon = d[B_XON];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] ctl_bits(input ctl_t c);
    logic [REG_W-1:0] d;
    d = '0;
    d[B_WUT] = c.wut;
    d[B_LBD] = c.lbd;
    d[B_TS]  = c.ts;
    d[B_PLL] = c.pll;
    d[B_XON] = c.xon;
    return d;
  endfunction

  // priority: TUNE > READY > SENSOR > SLEEP > STANDBY
  function automatic pm_mode_e pm_decode(input ctl_t c);
    if (c.pll)              return PM_TUNE;
    else if (c.xon)         return PM_READY;
    else if (c.lbd || c.ts) return PM_SENSE;
    else if (c.wut)         return PM_SLEEP;
    else                    return PM_STBY;
  endfunction

  function automatic logic pm_is_low(input pm_mode_e m);
    return (m == PM_STBY) || (m == PM_SLEEP) || (m == PM_SENSE);
  endfunction
endpackage

// File: rtl/pmc_regs.sv
`timescale 1ns/1ps
module pmc_regs
  import pmc_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int CTL_ADDR  = 0,
  parameter int XCTL_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shdn,
  input  logic              por,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output ctl_t              ctl_q,
  output logic [REG_W-1:0]  xctl_q
);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(CTL_ADDR);
  localparam logic [ADDR_W-1:0] A_XCTL = ADDR_W'(XCTL_ADDR);

  ctl_t ctl_wr;
  logic wr_ctl, wr_xctl, swrst, locked, to_default;

  assign ctl_wr     = ctl_of(wdata);
  assign wr_ctl     = wr_en && (addr == A_CTL);
  assign wr_xctl    = wr_en && (addr == A_XCTL);
  assign swrst      = wr_ctl && wdata[B_SWRST];
  // leaving READY is refused while the buffer override is set
  assign locked     = xctl_q[B_BUFOVR] && (pm_decode(ctl_q) == PM_READY) &&
                      (pm_decode(ctl_wr) != PM_READY);
  assign to_default = rst || por || swrst;

  always_ff @(posedge clk) begin
    if (shdn) begin
      ctl_q  <= '0;
      xctl_q <= '0;
    end else if (to_default) begin
      ctl_q  <= CTL_DEF;
      xctl_q <= XCTL_DEF;
    end else begin
      if (wr_ctl && !locked) ctl_q  <= ctl_wr;
      if (wr_xctl)           xctl_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (shdn || rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      if (addr == A_CTL)       rdata <= ctl_bits(ctl_q);
      else if (addr == A_XCTL) rdata <= xctl_q;
      else                     rdata <= '0;
    end
  end

  // R2: reads during shutdown return zero
  a_r2_shdn_rdata_zero: assert property (@(posedge clk) disable iff (rst)
    shdn |=> (rdata == '0));

  // R3: power-on reset restores defaults
  a_r3_por_defaults: assert property (@(posedge clk) disable iff (rst)
    (por && !shdn) |=> (ctl_q == CTL_DEF && xctl_q == XCTL_DEF));

  // R10: write leaving READY under buffer override is dropped
  a_r10_locked_hold: assert property (@(posedge clk) disable iff (rst)
    (!shdn && !por && wr_ctl && !wdata[B_SWRST] && locked) |=> $stable(ctl_q));

  // R11: software reset restores defaults
  a_r11_swrst_default: assert property (@(posedge clk) disable iff (rst)
    (!shdn && swrst) |=> (ctl_q == CTL_DEF && xctl_q == XCTL_DEF));
endmodule

// File: rtl/pmc_irq.sv
`timescale 1ns/1ps
module pmc_irq (
  input  logic clk,
  input  logic rst,
  input  logic shdn,
  input  logic por,
  input  logic irq_n,
  input  logic irq_rd,
  output logic pend
);
  logic irq_n_q, irq_fall;

  assign irq_fall = irq_n_q && !irq_n;

  always_ff @(posedge clk) begin
    if (rst || shdn) irq_n_q <= 1'b1;
    else             irq_n_q <= irq_n;
  end

  // a new interrupt edge wins over a read in the same cycle
  always_ff @(posedge clk) begin
    if (shdn)                  pend <= 1'b0;
    else if (rst || por)       pend <= 1'b1;
    else if (irq_fall)         pend <= 1'b1;
    else if (irq_rd)           pend <= 1'b0;
  end

  // R12: a status read clears the pending flag
  a_r12_read_clears: assert property (@(posedge clk) disable iff (rst)
    (!shdn && !por && !irq_fall && irq_rd) |=> !pend);

  // R12: a falling interrupt line sets it
  a_r12_fall_sets: assert property (@(posedge clk) disable iff (rst)
    (!shdn && irq_fall) |=> pend);
endmodule

// File: rtl/pmc_decode.sv
`timescale 1ns/1ps
module pmc_decode
  import pmc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             shdn,
  input  logic             por,
  input  ctl_t             ctl,
  input  logic             bufovr,
  input  logic             pend,
  output logic [EN_W-1:0]  en,      // {ldo, wut, lbd, ts, xtal, xbuf, pll}
  output logic [2:0]       mode_code,
  output logic             min_current
);
  pm_mode_e        m;
  logic [EN_W-1:0] en_nxt;
  logic            xtal_nxt;

  always_comb begin
    m        = pm_decode(ctl);
    xtal_nxt = ctl.xon || ctl.pll;
    en_nxt   = {1'b1,
                ctl.wut || (m == PM_SENSE),
                ctl.lbd,
                ctl.ts,
                xtal_nxt,
                xtal_nxt && !bufovr,
                ctl.pll};
  end

  always_ff @(posedge clk) begin
    if (rst || shdn || por) begin
      en          <= '0;
      mode_code   <= PM_OFF;
      min_current <= 1'b0;
    end else begin
      en          <= en_nxt;
      mode_code   <= m;
      min_current <= pm_is_low(m) && !pend;
    end
  end

  // R2: shutdown turns everything off
  a_r2_shdn_off: assert property (@(posedge clk) disable iff (rst)
    shdn |=> (en == '0 && mode_code == PM_OFF && !min_current));

  // R8: PLL-on selects TUNE with the crystal forced on
  a_r8_tune_xtal: assert property (@(posedge clk) disable iff (rst)
    (!shdn && !por && ctl.pll) |=> (en[0] && en[2] && mode_code == PM_TUNE));

  // R12: minimum current only after the pending flag was clear
  a_r12_min_needs_clear: assert property (@(posedge clk) disable iff (rst)
    min_current |-> !$past(pend));
endmodule

// File: rtl/radio_idle_pmc.sv
`timescale 1ns/1ps
module radio_idle_pmc
  import pmc_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int CTL_ADDR  = 0,
  parameter int XCTL_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shdn,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              irq_n,
  input  logic              irq_rd,
  output logic              en_ldo,
  output logic              en_wut,
  output logic              en_lbd,
  output logic              en_tsen,
  output logic              en_xtal,
  output logic              en_xbuf,
  output logic              en_pll,
  output logic [2:0]        mode_code,
  output logic              min_current
);
  logic             shdn_prev, por, pend;
  ctl_t             ctl_q;
  logic [REG_W-1:0] xctl_q;
  logic [EN_W-1:0]  en;

  always_ff @(posedge clk) begin
    if (rst) shdn_prev <= 1'b0;
    else     shdn_prev <= shdn;
  end
  assign por = shdn_prev && !shdn;

  pmc_regs #(
    .ADDR_W(ADDR_W), .CTL_ADDR(CTL_ADDR), .XCTL_ADDR(XCTL_ADDR)
  ) u_regs (
    .clk(clk), .rst(rst), .shdn(shdn), .por(por),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ctl_q(ctl_q), .xctl_q(xctl_q)
  );

  pmc_irq u_irq (
    .clk(clk), .rst(rst), .shdn(shdn), .por(por),
    .irq_n(irq_n), .irq_rd(irq_rd), .pend(pend)
  );

  pmc_decode u_dec (
    .clk(clk), .rst(rst), .shdn(shdn), .por(por),
    .ctl(ctl_q), .bufovr(xctl_q[B_BUFOVR]), .pend(pend),
    .en(en), .mode_code(mode_code), .min_current(min_current)
  );

  assign {en_ldo, en_wut, en_lbd, en_tsen, en_xtal, en_xbuf, en_pll} = en;

  // R3: one off cycle after the pin falls, then READY
  a_r3_por_then_ready: assert property (@(posedge clk) disable iff (rst)
    (por && !shdn) |=> ##1 (shdn || mode_code == PM_READY));
endmodule

// File: tb/radio_idle_pmc_bench.sv
`timescale 1ns/1ps
module radio_idle_pmc_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       shdn = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq_n = 1'b1;
  logic       irq_rd = 1'b0;
  logic       en_ldo, en_wut, en_lbd, en_tsen, en_xtal, en_xbuf, en_pll;
  logic [2:0] mode_code;
  logic       min_current;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  radio_idle_pmc u_radio_idle_pmc (
    .clk(clk), .rst(rst), .shdn(shdn), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_n(irq_n), .irq_rd(irq_rd),
    .en_ldo(en_ldo), .en_wut(en_wut), .en_lbd(en_lbd), .en_tsen(en_tsen),
    .en_xtal(en_xtal), .en_xbuf(en_xbuf), .en_pll(en_pll),
    .mode_code(mode_code), .min_current(min_current)
  );

  function automatic logic [6:0] ens();
    return {en_ldo, en_wut, en_lbd, en_tsen, en_xtal, en_xbuf, en_pll};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic status_read();
    irq_rd = 1'b1;
    @(negedge clk);
    irq_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    repeat (3) @(negedge clk);
    check("R1 en in reset", ens(), 7'b0000000);
    check("R1 mode in reset", mode_code, 3'd0);
    check("R1 min in reset", min_current, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 mode after reset", mode_code, 3'd4);
    check("R1 en after reset", ens(), 7'b1000110);
    check("R1 min after reset", min_current, 1'b0);
    rd(4'd0, d); check("R1 mode reg default", d, 8'h01);
    rd(4'd1, d); check("R1 xctl default", d, 8'h00);
  endtask

  task automatic t_standby();
    wr(4'd0, 8'h00);
    check("R4 standby mode", mode_code, 3'd1);
    check("R4 standby en", ens(), 7'b1000000);
    check("R12 pending after reset", min_current, 1'b0);
    status_read();
    check("R12 min after read", min_current, 1'b1);
  endtask

  task automatic t_sleep();
    wr(4'd0, 8'h40);
    check("R5 sleep mode", mode_code, 3'd2);
    check("R5 sleep en", ens(), 7'b1100000);
    check("R12 min in sleep", min_current, 1'b1);
    irq_n = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R12 irq blocks min", min_current, 1'b0);
    status_read();
    check("R12 read with line low", min_current, 1'b1);
    irq_n = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R12 line release no effect", min_current, 1'b1);
  endtask

  task automatic t_sensor();
    wr(4'd0, 8'h20);
    check("R6 sensor lbd mode", mode_code, 3'd3);
    check("R6 sensor lbd en", ens(), 7'b1110000);
    wr(4'd0, 8'h10);
    check("R6 sensor ts mode", mode_code, 3'd3);
    check("R6 sensor ts en", ens(), 7'b1101000);
    wr(4'd0, 8'h30);
    check("R6 sensor both en", ens(), 7'b1111000);
    check("R12 min in sensor", min_current, 1'b1);
  endtask

  task automatic t_tune();
    wr(4'd0, 8'h02);
    check("R8 tune mode", mode_code, 3'd5);
    check("R8 tune en", ens(), 7'b1000111);
    check("R12 no min in tune", min_current, 1'b0);
    wr(4'd0, 8'h01);
    check("R7 ready mode", mode_code, 3'd4);
    check("R7 ready en", ens(), 7'b1000110);
  endtask

  task automatic t_priority();
    wr(4'd0, 8'h73);
    check("R9 all bits tune", mode_code, 3'd5);
    check("R9 all bits en", ens(), 7'b1111111);
    wr(4'd0, 8'h61);
    check("R9 ready over sensor", mode_code, 3'd4);
    check("R9 ready over sensor en", ens(), 7'b1110110);
    wr(4'd0, 8'h50);
    check("R9 sensor over sleep", mode_code, 3'd3);
    check("R9 sensor over sleep en", ens(), 7'b1101000);
  endtask

  task automatic t_bufovr();
    logic [7:0] d;
    wr(4'd0, 8'h01);
    wr(4'd1, 8'h02);
    check("R7 buffer override en", ens(), 7'b1000100);
    rd(4'd1, d); check("R7 xctl readback", d, 8'h02);
    wr(4'd0, 8'h00);
    rd(4'd0, d); check("R10 standby write dropped", d, 8'h01);
    check("R10 still ready", mode_code, 3'd4);
    wr(4'd0, 8'h03);
    check("R10 tune write dropped", mode_code, 3'd4);
    wr(4'd1, 8'h00);
    check("R7 buffer back on", ens(), 7'b1000110);
    wr(4'd0, 8'h00);
    check("R10 leave after clear", mode_code, 3'd1);
  endtask

  task automatic t_swrst();
    logic [7:0] d;
    wr(4'd1, 8'h02);
    wr(4'd0, 8'h7F);
    rd(4'd0, d); check("R11 stored bits mask", d, 8'h73);
    check("R11 tune with ovr en", ens(), 7'b1111101);
    wr(4'd0, 8'h80);
    rd(4'd0, d); check("R11 swrst mode reg", d, 8'h01);
    rd(4'd1, d); check("R11 swrst xctl", d, 8'h00);
    check("R11 swrst mode", mode_code, 3'd4);
    check("R11 swrst en", ens(), 7'b1000110);
  endtask

  task automatic t_shutdown();
    logic [7:0] d;
    wr(4'd0, 8'h40);
    wr(4'd1, 8'h55);
    shdn = 1'b1;
    @(negedge clk);
    check("R2 shdn en", ens(), 7'b0000000);
    check("R2 shdn mode", mode_code, 3'd0);
    check("R2 shdn min", min_current, 1'b0);
    wr(4'd0, 8'h02);
    check("R2 write ignored", mode_code, 3'd0);
    rd(4'd0, d); check("R2 read zero", d, 8'h00);
    shdn = 1'b0;
    @(negedge clk);
    check("R3 off cycle", mode_code, 3'd0);
    @(negedge clk);
    check("R3 ready after por", mode_code, 3'd4);
    check("R3 ready en", ens(), 7'b1000110);
    rd(4'd0, d); check("R3 mode reg default", d, 8'h01);
    rd(4'd1, d); check("R3 xctl default", d, 8'h00);
    wr(4'd0, 8'h00);
    check("R12 pending after por", min_current, 1'b0);
    status_read();
    check("R12 min after por read", min_current, 1'b1);
  endtask

  initial begin
    t_reset();
    t_standby();
    t_sleep();
    t_sensor();
    t_tune();
    t_priority();
    t_bufovr();
    t_swrst();
    t_shutdown();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule